// File: doc/BRIEF.md
# Always-On Register Bank with Power-Mode Reset Gating

This block holds the software-visible state of an always-on, low-power domain: a counter, two match values, a load value, a control word, an interrupt mask with raw and masked status, a write-one-to-clear register, a trim word and a 64-word scratch memory. Software reaches it through a 32-bit memory-mapped request port addressed by word offset. Read data returns on a response port one cycle after the request.

The central job is reset gating. A system reset request clears the bank only when the module is not enabled. While the module is enabled, in normal run, hibernating or waking from hibernation, the request leaves the registers untouched and only frees the bus interface. A supply-change event seen while no external voltage is present clears the whole bank whatever the mode. The gated clear is driven out on `bank_clr` so that the surrounding logic can observe it.

Registers that live in the slow clock domain must not be written back to back. The bank paces them: after an accepted slow write, further slow writes are dropped for a parameterised gap and a sticky error flag records each dropped write. The request port never back-pressures (`req_ready` is held high), so the pacing shows up as dropped writes and not as stalls. The response port has no ready signal. `rsp_valid` is high for exactly one cycle per accepted read, and the consumer must take the data in that cycle.

Top module: `aon_regbank`

## Requirements
- R1: Word offsets are: counter 0, match A 1, match B 2, load 3, control 4, mask 5, raw status 6, masked status 7, clear 8, trim 9, scratch words 12 to 75. Offsets 10, 11 and 76 and above read as zero. A read accepted on one clock edge sets `rsp_valid` for the following cycle only, with `rsp_rdata` holding the value the register had before that edge.
- R2: After `rst_n` or a bank clear, match A, match B and load read 0xFFFFFFFF, trim reads 0x00007FFF, and every other register, including all scratch words, reads zero.
- R3: Writes to the counter, raw status and masked status offsets change nothing.
- R4: Writing the clear register clears every raw status bit whose write-data bit is 1 and leaves bits written with 0 unchanged. A bit set by `evt_set` in the same cycle stays set.
- R5: Raw status and mask occupy bits [3:0], with upper bits reading zero. `evt_set[i]` sets raw bit i. Masked status reads raw AND mask, and `irq` is high when any masked bit is set.
- R6: Writes to match A, match B, load, trim and the scratch words are slow writes. After an accepted slow write, the next slow write is accepted only if it comes at least WR_GAP (default 4) cycles later. `busy` is high during the cycles in which a slow write would be dropped.
- R7: A slow write that arrives while `busy` is high is dropped and sets `wr_err`. `wr_err` stays set until `rst_n` or a bank clear. Writes to control, mask and clear are never dropped.
- R8: `supply_evt` with `ext_pwr` low clears the bank in any mode. With `ext_pwr` high, `supply_evt` has no effect.
- R9: `rst_req` while `mod_en` is low clears the bank.
- R10: `rst_req` while `mod_en` is high leaves every register unchanged in normal run, while hibernating (`hib_active`) and while waking (`hib_exit`). It still ends any `busy` window.
- R11: An accepted load write also copies the data into the counter.
- R12: `bank_clr` is high in the same cycle as the input condition of R8 or R9, and the clear takes effect on the next clock edge, taking priority over any write on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous power-up reset of the domain, active low |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready, always high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle per read |
| rsp_rdata | output | 32 | Read data |
| rst_req | input | 1 | Incoming system reset request |
| mod_en | input | 1 | Module enabled by software |
| hib_active | input | 1 | Module is hibernating |
| hib_exit | input | 1 | Module is returning from hibernation |
| ext_pwr | input | 1 | External voltage present |
| supply_evt | input | 1 | Pulse on a main or battery supply change |
| evt_set | input | 4 | Event pulses setting raw status bits |
| irq | output | 1 | OR of masked status |
| busy | output | 1 | Slow-write spacing window active |
| wr_err | output | 1 | Sticky dropped-write flag |
| bank_clr | output | 1 | Gated bank clear |

## Verification
Assertions check on every cycle that a bank clear leaves reset values on the following edge, that an enabled reset request without power loss keeps the control and match registers stable, that write-one-to-clear removes the addressed raw bits unless re-set, that responses follow reads, and that the pacing counter reloads correctly and flags dropped writes. Only the bench's scenarios can show the full register map and read values, the exact cycle at which a spaced slow write is accepted again, the mode-by-mode behaviour of reset requests against stored data, and the load-to-counter copy. These are checked against a reference model under directed and seeded random traffic.

// File: rtl/aon_pkg.sv
package aon_pkg;
  localparam int unsigned WI_CNT   = 0;
  localparam int unsigned WI_MTA   = 1;
  localparam int unsigned WI_MTB   = 2;
  localparam int unsigned WI_LOAD  = 3;
  localparam int unsigned WI_CTL   = 4;
  localparam int unsigned WI_MASK  = 5;
  localparam int unsigned WI_RAW   = 6;
  localparam int unsigned WI_MSKD  = 7;
  localparam int unsigned WI_CLR   = 8;
  localparam int unsigned WI_TRIM  = 9;
  localparam int unsigned WI_DATA0 = 12;

  localparam logic [31:0] RV_ONES = 32'hFFFF_FFFF;
  localparam logic [31:0] RV_TRIM = 32'h0000_7FFF;

  typedef enum logic [1:0] {
    PM_OFF  = 2'd0,
    PM_RUN  = 2'd1,
    PM_HIB  = 2'd2,
    PM_WAKE = 2'd3
  } pmode_e;
endpackage

// File: rtl/aon_rst_gate.sv
module aon_rst_gate
  import aon_pkg::*;
(
  input  logic   rst_req,
  input  logic   mod_en,
  input  logic   hib_active,
  input  logic   hib_exit,
  input  logic   ext_pwr,
  input  logic   supply_evt,
  output pmode_e pmode,
  output logic   bank_clr,
  output logic   if_clr
);
  logic pwr_loss;

  always_comb begin
    if (!mod_en)         pmode = PM_OFF;
    else if (hib_exit)   pmode = PM_WAKE;
    else if (hib_active) pmode = PM_HIB;
    else                 pmode = PM_RUN;
  end

  assign pwr_loss = supply_evt & ~ext_pwr;

  always_comb begin
    bank_clr = pwr_loss;
    unique case (pmode)
      PM_OFF:  bank_clr = pwr_loss | rst_req;
      PM_RUN,
      PM_HIB,
      PM_WAKE: bank_clr = pwr_loss;
      default: bank_clr = pwr_loss;
    endcase
  end

  assign if_clr = rst_req | bank_clr;
endmodule

// File: rtl/aon_wr_pacer.sv
module aon_wr_pacer #(
  parameter int unsigned GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic if_clr,
  input  logic slow_wr,
  output logic accept,
  output logic busy,
  output logic err
);
  localparam int unsigned CW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(GAP - 1);

  logic [CW-1:0] cnt_q;

  assign busy   = (cnt_q != '0);
  assign accept = slow_wr & ~busy & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (if_clr)  cnt_q <= '0;
    else if (accept)  cnt_q <= RELOAD;
    else if (busy)    cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                err <= 1'b0;
    else if (clr)              err <= 1'b0;
    else if (slow_wr && busy)  err <= 1'b1;
  end

  // R6
  pace_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !if_clr) |=> (cnt_q == RELOAD));
  // R6
  pace_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD);
  // R7
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_wr && busy && !clr) |=> err);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err);
endmodule

// File: rtl/aon_data_mem.sv
module aon_data_mem #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [WORDS-1:0][DW-1:0] rd_bus;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         word_q <= '0;
      else if (clr)                       word_q <= '0;
      else if (we && widx == IW'(g))      word_q <= wdata;
    end
    assign rd_bus[g] = word_q;
  end

  assign rdata = rd_bus[ridx];
endmodule

// File: rtl/aon_regbank.sv
module aon_regbank
  import aon_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 32,
  parameter int unsigned DATA_WORDS = 64,
  parameter int unsigned WR_GAP     = 4,
  parameter int unsigned NEVT       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  input  logic            rst_req,
  input  logic            mod_en,
  input  logic            hib_active,
  input  logic            hib_exit,
  input  logic            ext_pwr,
  input  logic            supply_evt,
  input  logic [NEVT-1:0] evt_set,
  output logic            irq,
  output logic            busy,
  output logic            wr_err,
  output logic            bank_clr
);
  localparam int unsigned IW     = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;
  localparam int unsigned D_LAST = WI_DATA0 + DATA_WORDS - 1;
  localparam logic [DW-1:0] RV_MATCH = DW'(RV_ONES);
  localparam logic [DW-1:0] RV_TRM   = DW'(RV_TRIM);

  pmode_e pmode;
  logic   if_clr;
  logic   wr, rd, slow_wr, accept;
  logic   hit_cnt, hit_mta, hit_mtb, hit_load, hit_ctl, hit_mask;
  logic   hit_clr, hit_trim, hit_data;
  logic [AW-1:0]   doff;
  logic [IW-1:0]   didx;
  logic [DW-1:0]   mem_rd, rd_val;
  logic [NEVT-1:0] clr_bits;

  logic [DW-1:0]   cnt_q, mta_q, mtb_q, load_q, ctl_q, trim_q;
  logic [NEVT-1:0] raw_q, mask_q;

  aon_rst_gate u_gate (
    .rst_req    (rst_req),
    .mod_en     (mod_en),
    .hib_active (hib_active),
    .hib_exit   (hib_exit),
    .ext_pwr    (ext_pwr),
    .supply_evt (supply_evt),
    .pmode      (pmode),
    .bank_clr   (bank_clr),
    .if_clr     (if_clr)
  );

  assign req_ready = 1'b1;
  assign wr = req_valid & req_write;
  assign rd = req_valid & ~req_write;

  assign hit_cnt  = (int'(req_addr) == WI_CNT);
  assign hit_mta  = (int'(req_addr) == WI_MTA);
  assign hit_mtb  = (int'(req_addr) == WI_MTB);
  assign hit_load = (int'(req_addr) == WI_LOAD);
  assign hit_ctl  = (int'(req_addr) == WI_CTL);
  assign hit_mask = (int'(req_addr) == WI_MASK);
  assign hit_clr  = (int'(req_addr) == WI_CLR);
  assign hit_trim = (int'(req_addr) == WI_TRIM);
  assign hit_data = (int'(req_addr) >= WI_DATA0) && (int'(req_addr) <= D_LAST);

  assign doff = req_addr - AW'(WI_DATA0);
  assign didx = doff[IW-1:0];

  assign slow_wr = wr & (hit_mta | hit_mtb | hit_load | hit_trim | hit_data);

  aon_wr_pacer #(.GAP(WR_GAP)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (bank_clr),
    .if_clr  (if_clr),
    .slow_wr (slow_wr),
    .accept  (accept),
    .busy    (busy),
    .err     (wr_err)
  );

  aon_data_mem #(.WORDS(DATA_WORDS), .DW(DW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (bank_clr),
    .we    (accept & hit_data),
    .widx  (didx),
    .wdata (req_wdata),
    .ridx  (didx),
    .rdata (mem_rd)
  );

  // Slow-domain registers: written only when the pacer accepts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mta_q  <= RV_MATCH;
      mtb_q  <= RV_MATCH;
      load_q <= RV_MATCH;
      trim_q <= RV_TRM;
      cnt_q  <= '0;
    end else if (bank_clr) begin
      mta_q  <= RV_MATCH;
      mtb_q  <= RV_MATCH;
      load_q <= RV_MATCH;
      trim_q <= RV_TRM;
      cnt_q  <= '0;
    end else if (accept) begin
      if (hit_mta)  mta_q  <= req_wdata;
      if (hit_mtb)  mtb_q  <= req_wdata;
      if (hit_trim) trim_q <= req_wdata;
      if (hit_load) begin
        load_q <= req_wdata;
        cnt_q  <= req_wdata;
      end
    end
  end

  // Fast registers: never paced.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mask_q <= '0;
    end else if (bank_clr) begin
      ctl_q  <= '0;
      mask_q <= '0;
    end else if (wr) begin
      if (hit_ctl)  ctl_q  <= req_wdata;
      if (hit_mask) mask_q <= req_wdata[NEVT-1:0];
    end
  end

  assign clr_bits = (wr && hit_clr) ? req_wdata[NEVT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        raw_q <= '0;
    else if (bank_clr) raw_q <= '0;
    else               raw_q <= (raw_q & ~clr_bits) | evt_set;
  end

  assign irq = |(raw_q & mask_q);

  always_comb begin
    rd_val = '0;
    if (hit_data) rd_val = mem_rd;
    else begin
      case (int'(req_addr))
        WI_CNT:  rd_val = cnt_q;
        WI_MTA:  rd_val = mta_q;
        WI_MTB:  rd_val = mtb_q;
        WI_LOAD: rd_val = load_q;
        WI_CTL:  rd_val = ctl_q;
        WI_MASK: rd_val = DW'(mask_q);
        WI_RAW:  rd_val = DW'(raw_q);
        WI_MSKD: rd_val = DW'(raw_q & mask_q);
        WI_TRIM: rd_val = trim_q;
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_val;
    end
  end

  // R2
  clr_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_clr |=> (mta_q == RV_MATCH && mtb_q == RV_MATCH && load_q == RV_MATCH
                  && trim_q == RV_TRM && ctl_q == '0 && cnt_q == '0 && raw_q == '0));
  // R10
  keep_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && pmode != PM_OFF && !(supply_evt && !ext_pwr) && !wr)
      |=> ($stable(ctl_q) && $stable(mta_q) && $stable(trim_q) && $stable(mask_q)));
  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_clr && !bank_clr)
      |=> ((raw_q & $past(req_wdata[NEVT-1:0]) & ~$past(evt_set)) == '0));
  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd));
  // R3
  ro_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_cnt && !bank_clr && !accept) |=> $stable(cnt_q));
endmodule

// File: tb/sim_aon_regbank.sv
`timescale 1ns/1ps
module sim_aon_regbank;
  localparam int G = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rst_req = 1'b0, mod_en = 1'b1, hib_active = 1'b0, hib_exit = 1'b0;
  logic        ext_pwr = 1'b1, supply_evt = 1'b0;
  logic [3:0]  evt_set = '0;
  logic        req_ready, rsp_valid, irq, busy, wr_err, bank_clr;
  logic [31:0] rsp_rdata;

  int errors = 0, checks = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  aon_regbank #(.WR_GAP(G)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rst_req(rst_req),
    .mod_en(mod_en), .hib_active(hib_active), .hib_exit(hib_exit),
    .ext_pwr(ext_pwr), .supply_evt(supply_evt), .evt_set(evt_set),
    .irq(irq), .busy(busy), .wr_err(wr_err), .bank_clr(bank_clr));

  // reference model
  logic [31:0] m_cnt, m_mta, m_mtb, m_load, m_ctl, m_trim;
  logic [3:0]  m_raw, m_mask;
  logic [31:0] m_mem [64];
  int          m_busy;
  bit          m_err, e_rspv;
  logic [31:0] e_rdata;

  function automatic void model_reset();
    m_cnt = 0; m_mta = '1; m_mtb = '1; m_load = '1; m_ctl = 0; m_trim = 32'h7FFF;
    m_raw = 0; m_mask = 0; m_busy = 0; m_err = 0;
    for (int i = 0; i < 64; i++) m_mem[i] = 0;
  endfunction

  function automatic logic [31:0] exp_val(int w);
    if (w >= 12 && w <= 75) return m_mem[w-12];
    case (w)
      0: return m_cnt;  1: return m_mta;  2: return m_mtb;  3: return m_load;
      4: return m_ctl;  5: return {28'd0, m_mask}; 6: return {28'd0, m_raw};
      7: return {28'd0, m_raw & m_mask}; 9: return m_trim;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit is_slow(int w);
    return (w == 1 || w == 2 || w == 3 || w == 9 || (w >= 12 && w <= 75));
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit clr_e, slow, acc;
    int w;
    logic [31:0] d;
    logic [3:0] clrb;
    #1;
    clr_e = (supply_evt && !ext_pwr) || (rst_req && !mod_en);
    chk(bank_clr === clr_e, "R12 bank_clr", {31'd0, bank_clr}, {31'd0, clr_e});
    @(posedge clk);
    w = int'(req_addr); d = req_wdata;
    e_rspv = req_valid && !req_write;
    if (e_rspv) e_rdata = exp_val(w);
    if (clr_e) model_reset();
    else begin
      slow = req_valid && req_write && is_slow(w);
      acc = slow && (m_busy == 0);
      if (slow && m_busy != 0) m_err = 1;
      if (acc) begin
        if (w == 1) m_mta = d;
        if (w == 2) m_mtb = d;
        if (w == 3) begin m_load = d; m_cnt = d; end
        if (w == 9) m_trim = d;
        if (w >= 12 && w <= 75) m_mem[w-12] = d;
        m_busy = G - 1;
      end else if (m_busy > 0) m_busy--;
      if (rst_req) m_busy = 0;
      clrb = (req_valid && req_write && w == 8) ? d[3:0] : 4'd0;
      if (req_valid && req_write && w == 4) m_ctl = d;
      if (req_valid && req_write && w == 5) m_mask = d[3:0];
      m_raw = (m_raw & ~clrb) | evt_set;
    end
    @(negedge clk);
    chk(rsp_valid === e_rspv, {cur_tag, " rsp_valid"}, {31'd0, rsp_valid}, {31'd0, e_rspv});
    if (e_rspv) chk(rsp_rdata === e_rdata, {cur_tag, " rdata"}, rsp_rdata, e_rdata);
    chk(irq === |(m_raw & m_mask), "R5 irq", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
    chk(busy === (m_busy != 0), "R6 busy", {31'd0, busy}, {31'd0, m_busy != 0});
    chk(wr_err === m_err, "R7 wr_err", {31'd0, wr_err}, {31'd0, m_err});
  endtask

  task automatic idle();
    req_valid = 0; req_write = 0; evt_set = 0; rst_req = 0; supply_evt = 0;
  endtask

  task automatic wr(int w, logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = 8'(w); req_wdata = d; tick(); idle();
  endtask

  task automatic rd(int w);
    req_valid = 1; req_write = 0; req_addr = 8'(w); tick(); idle();
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic read_all_named();
    for (int w = 0; w < 12; w++) rd(w);
    rd(12); rd(75); rd(76);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);

    cur_tag = "R2"; read_all_named();

    cur_tag = "R5";
    wr(5, 32'h0000_00F5); evt_set = 4'b0110; tick(); idle();
    rd(6); rd(7); rd(5);

    cur_tag = "R4";
    evt_set = 4'b1111; tick(); idle();
    wr(8, 32'h0000_0005); rd(6);
    wr(8, 32'h0000_0000); rd(6);
    evt_set = 4'b0010; req_valid = 1; req_write = 1; req_addr = 8; req_wdata = 32'hF; tick(); idle();
    rd(6);

    cur_tag = "R3";
    wr(0, 32'hDEAD_BEEF); wr(6, 32'hF); wr(7, 32'hF); rd(0); rd(6); rd(7);

    cur_tag = "R6";
    wr(1, 32'h1111_0001); wr(1, 32'h2222_0002); rd(1);
    gap(G); wr(12, 32'hAAAA_5555);
    gap(G - 2); wr(13, 32'h0BAD_0BAD); rd(13);
    tick(); wr(13, 32'h600D_600D); rd(13); rd(12);
    cur_tag = "R7";
    wr(4, 32'hC0DE_0004); wr(4, 32'hC0DE_0005); rd(4);

    cur_tag = "R11";
    gap(G); wr(3, 32'h0000_1234); rd(0); rd(3);

    cur_tag = "R10";
    gap(G); wr(2, 32'h5A5A_5A5A);
    mod_en = 1; rst_req = 1; tick(); idle();
    wr(9, 32'h0000_0033); rd(9);
    hib_active = 1; rst_req = 1; tick(); idle(); rd(2); rd(4);
    hib_exit = 1; rst_req = 1; tick(); idle(); rd(9); rd(13);
    hib_active = 0; hib_exit = 0;

    cur_tag = "R8";
    ext_pwr = 1; supply_evt = 1; tick(); idle(); rd(2);
    hib_active = 1; ext_pwr = 0; supply_evt = 1;
    req_valid = 1; req_write = 1; req_addr = 4; req_wdata = 32'h77; tick(); idle();
    ext_pwr = 1; hib_active = 0;
    read_all_named();

    cur_tag = "R9";
    wr(4, 32'h0000_0099); gap(G); wr(1, 32'h0000_0042);
    mod_en = 0; rst_req = 1; tick(); idle(); mod_en = 1;
    read_all_named();

    cur_tag = "R1";
    for (int n = 0; n < 4000; n++) begin
      req_valid = ($urandom % 2) == 0;
      req_write = ($urandom % 2) == 0;
      req_addr  = 8'($urandom % 82);
      req_wdata = $urandom;
      evt_set   = (($urandom % 8) == 0) ? 4'($urandom) : 4'd0;
      hib_active = ($urandom % 3) == 0;
      hib_exit   = ($urandom % 5) == 0;
      mod_en     = ($urandom % 4) != 0;
      rst_req    = ($urandom % 40) == 0;
      ext_pwr    = ($urandom % 2) == 0;
      supply_evt = ($urandom % 60) == 0;
      tick();
    end
    idle(); mod_en = 1; ext_pwr = 1;
    read_all_named();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule